// File: doc/BRIEF.md
# Two-Slot Linked Instruction Sequencer

The sequencer walks a program stored as a chain of memory words. Each word carries two instructions, a left one and a right one, and the address of the next word in the chain. The sequencer fetches a word, runs its left instruction, then runs its right instruction from the word register it already holds, and only then follows the link to fetch the next word. Flow changes through jumps, conditional jumps, a conditional halt, and subroutine call and return. Any other instruction is passed to an external execution unit through a valid/done handshake.

Jump and call targets are found indirectly. The 16-bit argument of the instruction indexes an external label table, and the sequencer reads the target word address back from that table in the same cycle. The subroutine stack saves the word address and the slot that was active at the call. On return the sequencer fetches that word again and resumes at the slot after the call. If the call sat in the left slot, the right instruction of the same word runs next. If the call sat in the right slot, the sequencer follows the word's link.

A start pulse loads the first word address. The sequencer then runs until it halts, and it stays halted until reset.

Top module: `tss_seq`

## Requirements
- R1: After reset, halt_o, mem_req_o and exec_valid_o are low, and nothing happens until start_i is pulsed.
- R2: A start_i pulse with a nonzero start_addr_i raises mem_req_o for that address. The request and its address stay unchanged until mem_ack_i. A word has the left instruction in bits 63:40, the right instruction in bits 39:16 and the link in bits 15:0. An instruction has its function in bits 23:16 and its argument in bits 15:0.
- R3: After a fetch, the left instruction is handled first and the right instruction second. No memory request is made between the two.
- R4: After the right instruction completes normally, the sequencer fetches the word at the link. A zero link halts it instead.
- R5: A function code other than 0x01 to 0x05 is issued on exec_valid_o with its function and argument. These stay stable until exec_done_i, and the sequencer advances only after exec_done_i.
- R6: Function 0x01 (jump) puts its argument on lbl_idx_o and fetches the word at lbl_tgt_i. The rest of the current word is skipped. Control functions never appear on the execute port.
- R7: Function 0x02 jumps like 0x01 when pred_i is high. When pred_i is low it does nothing and the next slot follows.
- R8: Function 0x03 halts when pred_i is high, and otherwise jumps like 0x01.
- R9: Function 0x04 (call) saves the word address and slot, then jumps. Function 0x05 (return) restores them and fetches that word again. It then runs the right slot if the call was in the left slot, or follows that word's link if the call was in the right slot.
- R10: The subroutine stack holds STACK_DEPTH entries (8 by default). A call when the stack is full halts the sequencer, and a return when the stack is empty halts it.
- R11: halt_o stays high until reset. start_i is ignored while the sequencer is running or halted. A zero label target halts the sequencer.
- R12: A start_i pulse with start_addr_i equal to zero halts the sequencer at once, without any fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| start_addr_i | input | ADDR_W | First word address |
| mem_req_o | output | 1 | Word fetch request |
| mem_addr_o | output | ADDR_W | Word address being fetched |
| mem_ack_i | input | 1 | Fetch data valid, one cycle |
| mem_rdata_i | input | WORD_W | Fetched word |
| lbl_idx_o | output | ADDR_W | Label table index, the argument of the current instruction |
| lbl_tgt_i | input | ADDR_W | Label table entry for lbl_idx_o, same cycle |
| pred_i | input | 1 | Predicate flip-flop value |
| exec_valid_o | output | 1 | Instruction offered to the execution unit |
| exec_func_o | output | FUNC_W | Function of the offered instruction |
| exec_addr_o | output | ADDR_W | Argument of the offered instruction |
| exec_done_i | input | 1 | Execution finished, one cycle |
| halt_o | output | 1 | Sequencer halted |

## Verification
The hardest case to reach is a return into a word whose register contents were already replaced by the subroutine's own fetches. It is harder still when the call came from the left slot, so that the sequencer must fetch the word again and resume in its right half. A filled stack that stops a call is also hard to reach. Directed programs place calls in each slot and build a self-recursive word that fills the stack. Random linked programs with random memory and execute latencies then mix jumps, calls and returns under both predicate values. The bench compares the full fetch and execute trace against a behavioural model of the chain.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic [2:0] {
    K_EXEC, K_JMP, K_JMPT, K_HALTT, K_CALL, K_RET
  } kind_e;

  typedef enum logic [1:0] {
    RM_LEFT, RM_RIGHT, RM_LINK
  } resume_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ISSUE, ST_EXEC, ST_HALT
  } state_e;

  localparam logic [7:0] FN_JMP   = 8'h01;
  localparam logic [7:0] FN_JMPT  = 8'h02;
  localparam logic [7:0] FN_HALTT = 8'h03;
  localparam logic [7:0] FN_CALL  = 8'h04;
  localparam logic [7:0] FN_RET   = 8'h05;

endpackage

// File: rtl/tss_word_split.sv
module tss_word_split #(
  parameter int FUNC_W = 8,
  parameter int ADDR_W = 16,
  localparam int INSTR_W = FUNC_W + ADDR_W,
  localparam int WORD_W  = 2 * INSTR_W + ADDR_W
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic               slot_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic [ADDR_W-1:0]  link_o
);

  logic [INSTR_W-1:0] slots [2];

  // slot 0 = left (top bits), slot 1 = right
  for (genvar g = 0; g < 2; g++) begin : g_slot
    assign slots[g] = word_i[WORD_W-1-g*INSTR_W -: INSTR_W];
  end

  assign instr_o = slots[slot_i];
  assign link_o  = word_i[ADDR_W-1:0];

endmodule

// File: rtl/tss_decode.sv
module tss_decode
  import tss_pkg::*;
#(
  parameter int FUNC_W = 8,
  parameter int ADDR_W = 16,
  localparam int INSTR_W = FUNC_W + ADDR_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  output kind_e              kind_o,
  output logic [FUNC_W-1:0]  func_o,
  output logic [ADDR_W-1:0]  arg_o
);

  assign func_o = instr_i[INSTR_W-1 -: FUNC_W];
  assign arg_o  = instr_i[ADDR_W-1:0];

  always_comb begin
    if      (func_o == FUNC_W'(FN_JMP))   kind_o = K_JMP;
    else if (func_o == FUNC_W'(FN_JMPT))  kind_o = K_JMPT;
    else if (func_o == FUNC_W'(FN_HALTT)) kind_o = K_HALTT;
    else if (func_o == FUNC_W'(FN_CALL))  kind_o = K_CALL;
    else if (func_o == FUNC_W'(FN_RET))   kind_o = K_RET;
    else                                  kind_o = K_EXEC;
  end

endmodule

// File: rtl/tss_sub_stack.sv
module tss_sub_stack #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              push_slot_i,
  output logic [ADDR_W-1:0] top_addr_o,
  output logic              top_slot_o,
  output logic              full_o,
  output logic              empty_o
);

  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic              ent_slot [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  wr_idx, top_idx;

  assign wr_idx  = IDX_W'(cnt_q);
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  assign top_addr_o = ent_addr[top_idx];
  assign top_slot_o = ent_slot[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_addr[i] <= '0;
        ent_slot[i] <= 1'b0;
      end
    end else if (push_i && !full_o) begin
      ent_addr[wr_idx] <= push_addr_i;
      ent_slot[wr_idx] <= push_slot_i;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  a_r10_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r10_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));

endmodule

// File: rtl/tss_seq.sv
module tss_seq
  import tss_pkg::*;
#(
  parameter int FUNC_W      = 8,
  parameter int ADDR_W      = 16,
  parameter int STACK_DEPTH = 8,
  localparam int INSTR_W = FUNC_W + ADDR_W,
  localparam int WORD_W  = 2 * INSTR_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] lbl_idx_o,
  input  logic [ADDR_W-1:0] lbl_tgt_i,
  input  logic              pred_i,
  output logic              exec_valid_o,
  output logic [FUNC_W-1:0] exec_func_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  input  logic              exec_done_i,
  output logic              halt_o
);

  state_e            state_q, state_d;
  resume_e           resume_q, resume_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic              slot_q, slot_d;

  logic [INSTR_W-1:0] cur_instr;
  logic [ADDR_W-1:0]  cur_link, rd_link, cur_arg;
  logic [FUNC_W-1:0]  cur_func;
  kind_e              cur_kind;

  logic              push, pop, stk_full, stk_empty, stk_slot;
  logic [ADDR_W-1:0] stk_addr;
  logic              jump_go, adv_go, halt_go;

  tss_word_split #(.FUNC_W(FUNC_W), .ADDR_W(ADDR_W)) u_split (
    .word_i  (word_q),
    .slot_i  (slot_q),
    .instr_o (cur_instr),
    .link_o  (cur_link)
  );

  tss_decode #(.FUNC_W(FUNC_W), .ADDR_W(ADDR_W)) u_dec (
    .instr_i (cur_instr),
    .kind_o  (cur_kind),
    .func_o  (cur_func),
    .arg_o   (cur_arg)
  );

  tss_sub_stack #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_addr_i (waddr_q),
    .push_slot_i (slot_q),
    .top_addr_o  (stk_addr),
    .top_slot_o  (stk_slot),
    .full_o      (stk_full),
    .empty_o     (stk_empty)
  );

  assign rd_link = mem_rdata_i[ADDR_W-1:0];

  always_comb begin
    state_d  = state_q;
    resume_d = resume_q;
    word_d   = word_q;
    waddr_d  = waddr_q;
    slot_d   = slot_q;
    push     = 1'b0;
    pop      = 1'b0;
    jump_go  = 1'b0;
    adv_go   = 1'b0;
    halt_go  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (start_addr_i == '0) begin
            halt_go = 1'b1;
          end else begin
            waddr_d  = start_addr_i;
            resume_d = RM_LEFT;
            state_d  = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack_i) begin
          word_d = mem_rdata_i;
          unique case (resume_q)
            RM_LINK: begin
              // returned from a right-slot call: skip on to the link
              if (rd_link == '0) begin
                halt_go = 1'b1;
              end else begin
                waddr_d  = rd_link;
                resume_d = RM_LEFT;
              end
            end
            RM_RIGHT: begin
              slot_d  = 1'b1;
              state_d = ST_ISSUE;
            end
            default: begin
              slot_d  = 1'b0;
              state_d = ST_ISSUE;
            end
          endcase
        end
      end
      ST_ISSUE: begin
        unique case (cur_kind)
          K_JMP:   jump_go = 1'b1;
          K_JMPT:  if (pred_i) jump_go = 1'b1; else adv_go = 1'b1;
          K_HALTT: if (pred_i) halt_go = 1'b1; else jump_go = 1'b1;
          K_CALL: begin
            if (stk_full) begin
              halt_go = 1'b1;
            end else begin
              push    = 1'b1;
              jump_go = 1'b1;
            end
          end
          K_RET: begin
            if (stk_empty) begin
              halt_go = 1'b1;
            end else begin
              pop      = 1'b1;
              waddr_d  = stk_addr;
              resume_d = stk_slot ? RM_LINK : RM_RIGHT;
              state_d  = ST_FETCH;
            end
          end
          default: state_d = ST_EXEC;
        endcase
      end
      ST_EXEC: begin
        if (exec_done_i) adv_go = 1'b1;
      end
      default: ;
    endcase

    if (jump_go) begin
      if (lbl_tgt_i == '0) begin
        halt_go = 1'b1;
      end else begin
        waddr_d  = lbl_tgt_i;
        resume_d = RM_LEFT;
        state_d  = ST_FETCH;
      end
    end

    if (adv_go) begin
      if (!slot_q) begin
        slot_d  = 1'b1;
        state_d = ST_ISSUE;
      end else if (cur_link == '0) begin
        halt_go = 1'b1;
      end else begin
        waddr_d  = cur_link;
        resume_d = RM_LEFT;
        state_d  = ST_FETCH;
      end
    end

    if (halt_go) state_d = ST_HALT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      resume_q <= RM_LEFT;
      word_q   <= '0;
      waddr_q  <= '0;
      slot_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= resume_d;
      word_q   <= word_d;
      waddr_q  <= waddr_d;
      slot_q   <= slot_d;
    end
  end

  assign mem_req_o    = (state_q == ST_FETCH);
  assign mem_addr_o   = waddr_q;
  assign lbl_idx_o    = cur_arg;
  assign exec_valid_o = (state_q == ST_EXEC);
  assign exec_func_o  = cur_func;
  assign exec_addr_o  = cur_arg;
  assign halt_o       = (state_q == ST_HALT);

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  a_r4_no_null_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o != '0);
  a_r5_exec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o && !exec_done_i |=>
      exec_valid_o && $stable(exec_func_o) && $stable(exec_addr_o));
  a_r3_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && exec_valid_o));
  a_r6_exec_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o |-> (exec_func_o < FUNC_W'(FN_JMP)) || (exec_func_o > FUNC_W'(FN_RET)));
  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

endmodule

// File: tb/tss_seq_tb.sv
`timescale 1ns/1ps
module tss_seq_tb;

  localparam int CAP   = 64;
  localparam int DEPTH = 8;

  logic        clk, rst_n;
  logic        start;
  logic [15:0] start_addr;
  logic        mem_req, mem_ack;
  logic [15:0] mem_addr;
  logic [63:0] mem_rdata;
  logic [15:0] lbl_idx, lbl_tgt;
  logic        pred;
  logic        exec_valid, exec_done;
  logic [7:0]  exec_func;
  logic [15:0] exec_addr;
  logic        halt;

  logic [63:0] mem [256];
  logic [15:0] lbl [256];

  logic [24:0] got  [CAP];
  logic [24:0] expv [CAP];
  int n_got, n_exp;
  bit exp_halt, trunc;
  int checks, errors;

  tss_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .lbl_idx_o(lbl_idx), .lbl_tgt_i(lbl_tgt),
    .pred_i(pred), .exec_valid_o(exec_valid), .exec_func_o(exec_func),
    .exec_addr_o(exec_addr), .exec_done_i(exec_done), .halt_o(halt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb lbl_tgt = lbl[lbl_idx[7:0]];

  function automatic logic [23:0] ins(input logic [7:0] f, input logic [15:0] a);
    return {f, a};
  endfunction

  function automatic logic [63:0] wrd(input logic [23:0] l, input logic [23:0] r,
                                      input logic [15:0] lk);
    return {l, r, lk};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expd);
    end
  endtask

  // memory responder, random latency 0..3
  initial begin
    int lat;
    mem_ack = 1'b0; mem_rdata = '0; lat = -1;
    forever begin
      @(negedge clk);
      if (!rst_n || mem_ack) begin
        mem_ack = 1'b0; lat = -1;
      end else if (mem_req) begin
        if (lat < 0) lat = $urandom_range(0, 3);
        if (lat == 0) begin
          mem_ack = 1'b1;
          mem_rdata = mem[mem_addr[7:0]];
          if (n_got < CAP) begin got[n_got] = {1'b0, 8'h00, mem_addr}; n_got++; end
        end else lat--;
      end else lat = -1;
    end
  end

  // execute responder
  initial begin
    int lat;
    exec_done = 1'b0; lat = -1;
    forever begin
      @(negedge clk);
      if (!rst_n || exec_done) begin
        exec_done = 1'b0; lat = -1;
      end else if (exec_valid) begin
        if (lat < 0) lat = $urandom_range(0, 3);
        if (lat == 0) begin
          exec_done = 1'b1;
          if (n_got < CAP) begin got[n_got] = {1'b1, exec_func, exec_addr}; n_got++; end
        end else lat--;
      end else lat = -1;
    end
  end

  task automatic add_exp(input logic [24:0] e);
    if (n_exp < CAP) begin expv[n_exp] = e; n_exp++; end
    if (n_exp >= CAP) trunc = 1'b1;
  endtask

  // behavioural model of the linked two-slot chain
  task automatic run_model(input logic [15:0] sa, input bit pv);
    logic [15:0] wa, stk_a [DEPTH];
    bit          stk_s [DEPTH];
    int          sp, mode;
    logic [63:0] w;
    bit          slot, brk;
    n_exp = 0; exp_halt = 1'b0; trunc = 1'b0; sp = 0;
    if (sa == 0) begin exp_halt = 1'b1; return; end
    wa = sa; mode = 0;
    while (!trunc && !exp_halt) begin
      add_exp({1'b0, 8'h00, wa});
      w = mem[wa[7:0]];
      if (mode == 2) begin
        if (w[15:0] == 0) exp_halt = 1'b1; else begin wa = w[15:0]; mode = 0; end
        continue;
      end
      slot = (mode == 1); brk = 1'b0;
      while (!brk && !trunc && !exp_halt) begin
        logic [23:0] it;
        logic [7:0]  f;
        logic [15:0] a, t;
        bit jmp, adv;
        it = slot ? w[39:16] : w[63:40];
        f = it[23:16]; a = it[15:0]; t = lbl[a[7:0]];
        jmp = 1'b0; adv = 1'b0;
        case (f)
          8'h01: jmp = 1'b1;
          8'h02: if (pv) jmp = 1'b1; else adv = 1'b1;
          8'h03: if (pv) exp_halt = 1'b1; else jmp = 1'b1;
          8'h04: if (sp == DEPTH) exp_halt = 1'b1;
                 else begin stk_a[sp] = wa; stk_s[sp] = slot; sp++; jmp = 1'b1; end
          8'h05: if (sp == 0) exp_halt = 1'b1;
                 else begin sp--; wa = stk_a[sp]; mode = stk_s[sp] ? 2 : 1; brk = 1'b1; end
          default: begin add_exp({1'b1, f, a}); adv = 1'b1; end
        endcase
        if (jmp) begin
          if (t == 0) exp_halt = 1'b1; else begin wa = t; mode = 0; brk = 1'b1; end
        end
        if (adv && !trunc) begin
          if (!slot) slot = 1'b1;
          else if (w[15:0] == 0) exp_halt = 1'b1;
          else begin wa = w[15:0]; mode = 0; brk = 1'b1; end
        end
      end
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) begin mem[i] = '0; lbl[i] = '0; end
  endtask

  task automatic run_test(input string req, input logic [15:0] sa, input bit pv);
    int lim;
    rst_n = 1'b0; start = 1'b0; start_addr = '0; pred = pv;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; n_got = 0;
    @(negedge clk);
    check(!halt && !mem_req && !exec_valid, "R1", "reset outputs",
          {halt, mem_req, exec_valid}, 0);
    run_model(sa, pv);
    start = 1'b1; start_addr = sa;
    @(negedge clk);
    start = 1'b0;
    lim = 0;
    while (!(halt || n_got >= CAP) && lim < 4000) begin
      @(negedge clk);
      lim++;
      if (lim == 3) begin start = 1'b1; start_addr = 16'h00aa; end
      if (lim == 4) start = 1'b0;
    end
    if (!trunc) check(n_got == n_exp, req, "event count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      check(got[i] === expv[i], req, $sformatf("event %0d", i), got[i], expv[i]);
    if (!trunc) begin
      check(halt == exp_halt, req, "halt", halt, exp_halt);
      if (halt) begin
        start = 1'b1; start_addr = 16'h0001;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(halt && !mem_req && !exec_valid, "R11", "start after halt",
              {halt, mem_req, exec_valid}, 3'b100);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    checks = 0; errors = 0; n_got = 0;
    rst_n = 1'b0; start = 1'b0; start_addr = '0; pred = 1'b0;

    // R2 R3 R4 R5: two plain words chained, link 0 ends
    clear_prog();
    mem[1] = wrd(ins(8'h40, 16'h11), ins(8'h41, 16'h12), 16'd2);
    mem[2] = wrd(ins(8'h42, 16'h13), ins(8'h43, 16'h14), 16'd0);
    run_test("R3", 16'd1, 1'b0);

    // R6: jump from left skips right
    clear_prog();
    lbl[5] = 16'd9;
    mem[1] = wrd(ins(8'h01, 16'd5), ins(8'h41, 16'h1), 16'd0);
    mem[9] = wrd(ins(8'h44, 16'h0), ins(8'h45, 16'h0), 16'd0);
    run_test("R6", 16'd1, 1'b0);

    // R7: conditional jump under both predicate values
    mem[1] = wrd(ins(8'h02, 16'd5), ins(8'h41, 16'h1), 16'd0);
    run_test("R7", 16'd1, 1'b0);
    run_test("R7", 16'd1, 1'b1);

    // R8: conditional halt under both predicate values
    mem[1] = wrd(ins(8'h03, 16'd5), ins(8'h41, 16'h1), 16'd0);
    run_test("R8", 16'd1, 1'b1);
    run_test("R8", 16'd1, 1'b0);

    // R9: call from left and right slots, return to each
    clear_prog();
    lbl[6] = 16'd20;
    mem[1]  = wrd(ins(8'h04, 16'd6), ins(8'h46, 16'h0), 16'd2);
    mem[20] = wrd(ins(8'h50, 16'h0), ins(8'h05, 16'h0), 16'd0);
    mem[2]  = wrd(ins(8'h47, 16'h0), ins(8'h04, 16'd6), 16'd3);
    mem[3]  = wrd(ins(8'h48, 16'h0), ins(8'h49, 16'h0), 16'd0);
    run_test("R9", 16'd1, 1'b0);

    // R10: self-recursive call fills the stack; return on empty stack
    clear_prog();
    lbl[7] = 16'd1;
    mem[1] = wrd(ins(8'h04, 16'd7), ins(8'h46, 16'h0), 16'd0);
    run_test("R10", 16'd1, 1'b0);
    mem[1] = wrd(ins(8'h05, 16'd0), ins(8'h46, 16'h0), 16'd0);
    run_test("R10", 16'd1, 1'b0);

    // R11: zero label target halts; R12: zero start address
    clear_prog();
    mem[1] = wrd(ins(8'h01, 16'd3), ins(8'h46, 16'h0), 16'd0);
    run_test("R11", 16'd1, 1'b0);
    run_test("R12", 16'd0, 1'b0);

    // random linked programs
    for (int n = 0; n < 40; n++) begin
      clear_prog();
      for (int a = 1; a < 32; a++) begin
        logic [23:0] s [2];
        logic [15:0] lk;
        for (int k = 0; k < 2; k++) begin
          int r;
          r = $urandom_range(0, 9);
          if (r < 5) s[k] = ins(8'h40 + 8'($urandom_range(0, 63)), 16'($urandom_range(0, 15)));
          else       s[k] = ins(8'(r - 4), 16'($urandom_range(0, 15)));
        end
        lk = ($urandom_range(0, 5) == 0) ? 16'd0 : 16'($urandom_range(1, 31));
        mem[a] = wrd(s[0], s[1], lk);
      end
      for (int i = 0; i < 16; i++) lbl[i] = 16'($urandom_range(0, 31));
      run_test("R9", 16'($urandom_range(1, 31)), 1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule